// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two component predictors. The first is indexed by a register that holds the most recent branch outcomes of the whole program. The second works in two levels: a per-branch history of recent outcomes selects a 3-bit saturating counter. A table of 2-bit chooser counters picks which of the two components supplies the final answer. The chooser is indexed by the same global history as the first component.

Prediction is purely combinational from the current state. The caller presents a PC and reads back the final direction and both component directions, and keeps the component bits with the branch. When the branch resolves, the caller presents the same PC, the real outcome and the two recorded component bits on the update port. The update trains the counters and shifts the outcome into both histories on the next rising clock edge. A prediction made in the same cycle as an update sees the state from before that update.

The default configuration uses a 12-bit global history, so both the chooser and the global table have 4096 entries. It uses 1024 local histories of 10 bits and 1024 local 3-bit counters.

Top module: `tourn_pred`

## Requirements
- R1: After reset every global counter is 1 (binary 01), every local counter is 3 (binary 011), every chooser counter is 1 (binary 01, favouring local), and all histories are zero. As a result, pred_taken, pred_glob and pred_loc are all 0 for every PC.
- R2: pred_glob is the MSB of the 2-bit global counter addressed by the global history register. Bit 0 of that register holds the most recent outcome and bit i holds the outcome i+1 branches back (1 = taken).
- R3: The local history entry for a branch is selected by PC bits [LIDX_W+1:2]. It holds the last LHIST_W outcomes of branches mapping to it, with the newest outcome in bit 0.
- R4: pred_loc is the MSB of the 3-bit local counter addressed by the local history entry selected for pred_pc.
- R5: pred_taken equals pred_glob when the chooser counter addressed by the global history has MSB 1, and equals pred_loc otherwise.
- R6: On an update, the global counter at the current global history and the local counter at the current local history of upd_pc both count up on taken and down on not taken. The 2-bit counters saturate at 0 and 3; the 3-bit counters saturate at 0 and 7.
- R7: The chooser counter at the current global history changes only when upd_glob differs from upd_loc. It counts up (toward global) when upd_glob equals upd_taken, counts down otherwise, and saturates at 0 and 3.
- R8: On an update, upd_taken is shifted into bit 0 of the global history and into bit 0 of the local history entry of upd_pc. The oldest bit is dropped from each.
- R9: While upd_valid is low, no state changes, whatever the other update inputs carry.
- R10: A prediction presented in the same cycle as an update reflects the state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_glob | output | 1 | Global component direction |
| pred_loc | output | 1 | Local component direction |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_glob | input | 1 | Global component bit recorded at predict time |
| upd_loc | input | 1 | Local component bit recorded at predict time |

## Verification
The bench builds the predictor with GHIST_W=3, LHIST_W=3, LIDX_W=2 and PC_W=8. This gives eight chooser and global counters, four local histories and eight local counters. With tables this small, a few thousand branches drive every counter into both saturation limits many times and make the chooser flip in both directions. The branch streams are a loop pattern, an alternating pattern, a globally correlated pattern and a pseudo-random pattern. Each prediction is compared against an arithmetic model of the tables, and at reset and during the stretch with updates disabled the bench sweeps every local-history index.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_WEAK = CTR_MAX >> 1;

  logic [CTR_W-1:0] mem_q [DEPTH];
  logic [CTR_W-1:0] cur_val;
  logic [CTR_W-1:0] nxt_val;

  assign rd_msb  = mem_q[rd_idx][CTR_W-1];
  assign cur_val = mem_q[wr_idx];

  always_comb begin
    nxt_val = cur_val;
    if (wr_up && cur_val != CTR_MAX)       nxt_val = cur_val + 1'b1;
    else if (!wr_up && cur_val != CTR_MIN) nxt_val = cur_val - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_WEAK;
    end else if (we) begin
      mem_q[wr_idx] <= nxt_val;
    end
  end

  // R6 / R7: saturation at both ends
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_up && cur_val == CTR_MAX) |=> mem_q[$past(wr_idx)] == CTR_MAX);
  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_up && cur_val == CTR_MIN) |=> mem_q[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic [HIST_W-1:0] rda_hist,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic [HIST_W-1:0] rdb_hist,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] hist_nxt;

  assign rda_hist = hist_q[rda_idx];
  assign rdb_hist = hist_q[rdb_idx];

  generate
    if (HIST_W > 1) begin : g_shift
      assign hist_nxt = {hist_q[wr_idx][HIST_W-2:0], wr_bit};
    end else begin : g_single
      assign hist_nxt = wr_bit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (we) begin
      hist_q[wr_idx] <= hist_nxt;
    end
  end

  // R3 / R8: newest outcome lands in bit 0 of the addressed entry
  a_r8_local_newest: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> hist_q[$past(wr_idx)][0] == $past(wr_bit));
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tourn_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12,
  parameter int LHIST_W = 10,
  parameter int LIDX_W  = 10,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int CCTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_glob,
  output logic            pred_loc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_glob,
  input  logic            upd_loc
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = LIDX_W + IDX_LO - 1;

  logic [GHIST_W-1:0] ghist_q, ghist_d;
  logic [LIDX_W-1:0]  p_lidx, u_lidx;
  logic [LHIST_W-1:0] p_lhist, u_lhist;
  logic               choose_msb;
  logic               chooser_we;
  pick_e              pick;
  logic               unused_pc;

  assign p_lidx    = pred_pc[IDX_HI:IDX_LO];
  assign u_lidx    = upd_pc[IDX_HI:IDX_LO];
  assign unused_pc = ^{pred_pc, upd_pc};

  tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist_tbl (
    .clk(clk), .rst_n(rst_n),
    .rda_idx(p_lidx), .rda_hist(p_lhist),
    .rdb_idx(u_lidx), .rdb_hist(u_lhist),
    .we(upd_valid), .wr_idx(u_lidx), .wr_bit(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_glob_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist_q), .rd_msb(pred_glob),
    .we(upd_valid), .wr_idx(ghist_q), .wr_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_loc_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(p_lhist), .rd_msb(pred_loc),
    .we(upd_valid), .wr_idx(u_lhist), .wr_up(upd_taken)
  );

  assign chooser_we = upd_valid && (upd_glob != upd_loc);

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) u_choose_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist_q), .rd_msb(choose_msb),
    .we(chooser_we), .wr_idx(ghist_q), .wr_up(upd_glob == upd_taken)
  );

  assign pick       = pick_e'(choose_msb);
  assign pred_taken = (pick == PICK_GLOBAL) ? pred_glob : pred_loc;

  generate
    if (GHIST_W > 1) begin : g_gshift
      always_comb begin
        ghist_d = ghist_q;
        if (upd_valid) ghist_d = {ghist_q[GHIST_W-2:0], upd_taken};
      end
    end else begin : g_gsingle
      always_comb begin
        ghist_d = ghist_q;
        if (upd_valid) ghist_d = upd_taken;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghist_q <= '0;
    else        ghist_q <= ghist_d;
  end

  // R8: outcome enters bit 0 of the global history
  a_r8_ghist_newest: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist_q[0] == $past(upd_taken));
  // R9: no update, no history movement
  a_r9_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist_q));
  // R5: when both components agree the choice is irrelevant
  a_r5_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_glob == pred_loc) |-> (pred_taken == pred_glob));
endmodule

// File: tb/tb_tourn_pred.sv
`timescale 1ns/1ps
module tb_tourn_pred;
  localparam int PC_W = 8, GW = 3, LHW = 3, LIW = 2;
  localparam int GN = 1 << GW, LHN = 1 << LIW, LCN = 1 << LHW;

  logic clk = 1'b0;
  logic rst_n;
  logic [PC_W-1:0] pred_pc, upd_pc;
  logic pred_taken, pred_glob, pred_loc;
  logic upd_valid, upd_taken, upd_glob, upd_loc;

  always #2 clk = ~clk;

  tourn_pred #(.PC_W(PC_W), .GHIST_W(GW), .LHIST_W(LHW), .LIDX_W(LIW)) dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_glob(pred_glob), .pred_loc(pred_loc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_glob(upd_glob), .upd_loc(upd_loc)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int gh;
  int gc [GN];
  int ch [GN];
  int lh [LHN];
  int lc [LCN];
  int cnt [LHN];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int mx, input bit up);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  function automatic bit m_glob();
    return gc[gh] >= 2;
  endfunction
  function automatic bit m_loc(input int idx);
    return lc[lh[idx]] >= 4;
  endfunction
  function automatic bit m_final(input int idx);
    return (ch[gh] >= 2) ? m_glob() : m_loc(idx);
  endfunction

  task automatic m_update(input int idx, input bit t, input bit g, input bit l);
    gc[gh] = sat(gc[gh], 3, t);
    lc[lh[idx]] = sat(lc[lh[idx]], 7, t);
    if (g != l) ch[gh] = sat(ch[gh], 3, g == t);
    gh = ((gh << 1) | int'(t)) & (GN - 1);
    lh[idx] = ((lh[idx] << 1) | int'(t)) & (LCN - 1);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check_pred(input int idx, input string tg);
    pred_pc = PC_W'(idx << 2);
    #1;
    chk({tg, " R2 global"}, int'(pred_glob), int'(m_glob()));
    chk({tg, " R4 R3 local"}, int'(pred_loc), int'(m_loc(idx)));
    chk({tg, " R5 R7 final"}, int'(pred_taken), int'(m_final(idx)));
  endtask

  // one resolved branch: predict and update in the same cycle (R10)
  task automatic branch(input int idx, input bit t);
    bit eg, el;
    @(negedge clk);
    eg = m_glob(); el = m_loc(idx);
    upd_valid = 1'b1; upd_pc = PC_W'(idx << 2);
    upd_taken = t; upd_glob = eg; upd_loc = el;
    check_pred(idx, "R10 R6 R8");
    @(posedge clk); #1;
    upd_valid = 1'b0;
    m_update(idx, t, eg, el);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pred_pc = '0; upd_pc = '0;
    upd_valid = 1'b0; upd_taken = 1'b0; upd_glob = 1'b0; upd_loc = 1'b0;
    gh = 0;
    for (int i = 0; i < GN; i++) begin gc[i] = 1; ch[i] = 1; end
    for (int i = 0; i < LHN; i++) begin lh[i] = 0; cnt[i] = 0; end
    for (int i = 0; i < LCN; i++) lc[i] = 3;
    #10; @(negedge clk); rst_n = 1'b1;

    // R1: reset state, every local index swept
    for (int i = 0; i < LHN; i++) begin
      @(negedge clk);
      pred_pc = PC_W'(i << 2); #1;
      chk("R1 taken", int'(pred_taken), 0);
      chk("R1 glob", int'(pred_glob), 0);
      chk("R1 loc", int'(pred_loc), 0);
    end

    // R6: one branch always taken drives counters to saturation
    for (int k = 0; k < 20; k++) branch(1, 1'b1);
    branch(1, 1'b0);
    @(negedge clk); check_pred(1, "R6 saturated");

    // mixed streams: loop, alternating, correlated, pseudo-random
    for (int s = 0; s < 3000; s++) begin
      int idx;
      bit t;
      step_lfsr();
      idx = int'(lfsr[1:0]);
      case (idx)
        0: t = (cnt[0] % 4) != 3;
        1: t = cnt[1][0];
        2: t = gh[0];
        default: t = lfsr[7];
      endcase
      cnt[idx]++;
      branch(idx, t);
    end

    // R9: update strobe low with busy data changes nothing
    for (int s = 0; s < 100; s++) begin
      step_lfsr();
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = PC_W'(lfsr[7:0]);
      upd_taken = lfsr[3]; upd_glob = lfsr[4]; upd_loc = lfsr[5];
      @(posedge clk); #1;
      @(negedge clk);
      for (int i = 0; i < LHN; i++) check_pred(i, "R9 hold");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule